// File: doc/BRIEF.md
# Five-State Power Sequencing Controller

This block decides which power state the whole system sits in and drives the signals that put the system into that state. There are five states: full-speed operation, a reduced-speed state where the processor runs at half rate, an idle state where the controller owns the system bus, a sleep state with the SDRAM in self-refresh and internal clocks stopped, and a deep-sleep state where the main oscillator and the PLLs are also off. Software moves the system between states with coded requests. Interrupts, DMA bus requests and four external wake sources bring it back.

The two deepest states can only be reached in order. Sleep requires that the controller already holds the bus, which it acquires in Idle. Deep sleep is reachable only from Sleep. The controller is clocked from the always-on slow clock, so wake detection keeps working when every other clock is off. Leaving deep sleep follows a fixed sequence. The oscillator and PLLs are switched on first. A software-programmed settling count then elapses. Next the clock gate and the self-refresh request are released. Only after that does the controller report full-speed operation.

Top module: `pmc_top`

## Requirements
- R1: `pm_state` reports the state as a code: 0 full speed, 1 half rate, 2 idle, 3 sleep, 4 deep sleep. After reset it reads 0. Software requests use the same codes on `sw_req_code` and are sampled only in cycles where `sw_req_valid` is high.
- R2: In state 0 the outputs are: `cpu_half_rate`, `bus_req` and `sdram_self_refresh` low; `clk_gate_en`, `osc_en` and every `pll_en` bit high.
- R3: In state 1 the outputs are the same as in state 0, except that `cpu_half_rate` is high. A request for code 0 or code 2 leaves state 1.
- R4: In state 2, `bus_req` is high. When `cpu_irq` or `dma_bus_req` is high, the next state is 0. This exit takes priority over any software request made in the same cycle.
- R5: A request for code 3 takes effect only when the state is 2 and `bus_grant` is high in that same cycle. In any other case the request is ignored and the state does not change.
- R6: In state 3, `sdram_self_refresh` is high, `clk_gate_en` is low, `bus_req` stays high, and the oscillator and PLLs stay enabled.
- R7: In deep sleep, before a wake event, `osc_en` and all `pll_en` bits are low, `sdram_self_refresh` is high and `clk_gate_en` is low.
- R8: The wake inputs are assigned as follows: bit 0 on-key, bit 1 alarm, bit 2 reset request, bit 3 ring indicate. A rising edge on any of them ends state 3. The edge is detected after a two-flop synchroniser, so the state reads 0 after the third rising clock edge following the input's rise.
- R9: `ring_irq` follows the synchronised ring-indicate input in states 0, 1 and 2, and is low in states 3 and 4.
- R10: Each wake edge seen in state 3, or in deep sleep before wake, sets the matching bit of `wake_cause`. The bits hold until a cycle with `cause_clr` high. A new wake edge in the same cycle as `cause_clr` wins over the clear.
- R11: A request for code 4 takes effect only from state 3. From any other state it is ignored. In deep sleep, every software request is ignored.
- R12: On a wake edge in deep sleep, `osc_en` and `pll_en` rise at the same clock edge that state 3 would have left. `clk_gate_en` rises and `sdram_self_refresh` falls `settle_cycles` clocks later (1 if programmed as 0). The state reads 0 one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req_valid | input | 1 | Software state request strobe |
| sw_req_code | input | 3 | Requested state code |
| cpu_irq | input | 1 | Processor interrupt pending |
| dma_bus_req | input | 1 | Peripheral DMA wants the bus |
| bus_grant | input | 1 | Bus arbiter grants the controller |
| wake_in | input | 4 | Asynchronous wake sources |
| settle_cycles | input | SETTLE_W (16) | Oscillator/PLL settling count |
| cause_clr | input | 1 | Clears the wake-cause record |
| pm_state | output | 3 | Current state code |
| cpu_half_rate | output | 1 | Processor half-rate select |
| bus_req | output | 1 | Controller bus request |
| sdram_self_refresh | output | 1 | SDRAM self-refresh request |
| clk_gate_en | output | 1 | Internal clock enable |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | NUM_PLL (2) | PLL enables |
| ring_irq | output | 1 | Ring-indicate interrupt |
| wake_cause | output | 4 | Sticky record of wake sources |

## Verification
The bench checks the gating of the deep states. It makes a sleep request without the grant, and a deep request from full speed. A controller that skipped the bus check would enter sleep while another master might still be mid-transfer, and the state code would show it. The bench counts the cycles of the deep-sleep exit exactly. A counter off by one, or a release that happens before the oscillator is enabled, moves the `clk_gate_en` edge out of its expected cycle. The bench also checks that an interrupt wins over a same-cycle sleep request, that ring indicate stays masked while asleep, and that a wake edge survives a simultaneous clear.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_SLOW  = 3'd1,
    PS_IDLE  = 3'd2,
    PS_SLEEP = 3'd3,
    PS_DEEP  = 3'd4
  } pm_state_e;

  typedef enum logic [1:0] {
    DP_OFF     = 2'd0,
    DP_SETTLE  = 2'd1,
    DP_RELEASE = 2'd2
  } deep_phase_e;

  localparam int NUM_WAKE  = 4;
  localparam int WAKE_RING = 3;

  // true when the settle count has reached its final cycle
  function automatic logic settle_last(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

  // states in which the main clocks run and ring goes to the interrupt line
  function automatic logic is_awake(input pm_state_e s);
    return (s == PS_RUN) || (s == PS_SLOW) || (s == PS_IDLE);
  endfunction

  // states in which a wake edge is honoured
  function automatic logic wake_armed(input pm_state_e s, input deep_phase_e p);
    return (s == PS_SLEEP) || ((s == PS_DEEP) && (p == DP_OFF));
  endfunction
endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_sync
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign level[i] = sync_q;
    assign rise[i]  = sync_q & ~prev_q;
  end
endmodule

// File: rtl/pmc_settle_cnt.sv
module pmc_settle_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] load_val,
  output logic         done
);
  import pmc_pkg::*;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && !settle_last(32'(cnt_q)))
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = run && settle_last(32'(cnt_q));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_req_valid,
  input  logic [2:0]  sw_req_code,
  input  logic        cpu_irq,
  input  logic        dma_bus_req,
  input  logic        bus_grant,
  input  logic        wake_any,
  input  logic        settle_done,
  output pm_state_e   state,
  output deep_phase_e phase,
  output logic        settle_load,
  output logic        settle_run
);
  pm_state_e   state_q, state_d;
  deep_phase_e phase_q, phase_d;

  logic req_run, req_slow, req_idle, req_sleep, req_deep;
  assign req_run   = sw_req_valid && (sw_req_code == PS_RUN);
  assign req_slow  = sw_req_valid && (sw_req_code == PS_SLOW);
  assign req_idle  = sw_req_valid && (sw_req_code == PS_IDLE);
  assign req_sleep = sw_req_valid && (sw_req_code == PS_SLEEP);
  assign req_deep  = sw_req_valid && (sw_req_code == PS_DEEP);

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    settle_load = 1'b0;
    case (state_q)
      PS_RUN: begin
        if (req_slow)      state_d = PS_SLOW;
        else if (req_idle) state_d = PS_IDLE;
      end
      PS_SLOW: begin
        if (req_run)       state_d = PS_RUN;
        else if (req_idle) state_d = PS_IDLE;
      end
      PS_IDLE: begin
        if (cpu_irq || dma_bus_req)   state_d = PS_RUN;
        else if (req_sleep && bus_grant) state_d = PS_SLEEP;
        else if (req_run)             state_d = PS_RUN;
        else if (req_slow)            state_d = PS_SLOW;
      end
      PS_SLEEP: begin
        if (wake_any) state_d = PS_RUN;
        else if (req_deep) begin
          state_d = PS_DEEP;
          phase_d = DP_OFF;
        end
      end
      PS_DEEP: begin
        case (phase_q)
          DP_OFF: if (wake_any) begin
            phase_d     = DP_SETTLE;
            settle_load = 1'b1;
          end
          DP_SETTLE: if (settle_done) phase_d = DP_RELEASE;
          default: begin
            state_d = PS_RUN;
            phase_d = DP_OFF;
          end
        endcase
      end
      default: begin
        state_d = PS_RUN;
        phase_d = DP_OFF;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      phase_q <= DP_OFF;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign state      = state_q;
  assign phase      = phase_q;
  assign settle_run = (state_q == PS_DEEP) && (phase_q == DP_SETTLE);
endmodule

// File: rtl/pmc_outdec.sv
module pmc_outdec
  import pmc_pkg::*;
#(
  parameter int NUM_PLL = 2
) (
  input  pm_state_e          state,
  input  deep_phase_e        phase,
  input  logic               ring_level,
  output logic               cpu_half_rate,
  output logic               bus_req,
  output logic               sdram_self_refresh,
  output logic               clk_gate_en,
  output logic               osc_en,
  output logic [NUM_PLL-1:0] pll_en,
  output logic               ring_irq
);
  logic in_deep, held_down;
  assign in_deep   = (state == PS_DEEP);
  assign held_down = (state == PS_SLEEP) || (in_deep && (phase != DP_RELEASE));

  assign cpu_half_rate      = (state == PS_SLOW);
  assign bus_req            = (state == PS_IDLE) || (state == PS_SLEEP) || in_deep;
  assign sdram_self_refresh = held_down;
  assign clk_gate_en        = !held_down;
  assign osc_en             = !(in_deep && (phase == DP_OFF));
  assign pll_en             = {NUM_PLL{osc_en}};
  assign ring_irq           = ring_level && is_awake(state);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int NUM_PLL  = 2,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_req_valid,
  input  logic [2:0]          sw_req_code,
  input  logic                cpu_irq,
  input  logic                dma_bus_req,
  input  logic                bus_grant,
  input  logic [3:0]          wake_in,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cause_clr,
  output logic [2:0]          pm_state,
  output logic                cpu_half_rate,
  output logic                bus_req,
  output logic                sdram_self_refresh,
  output logic                clk_gate_en,
  output logic                osc_en,
  output logic [NUM_PLL-1:0]  pll_en,
  output logic                ring_irq,
  output logic [3:0]          wake_cause
);
  logic [NUM_WAKE-1:0] wake_level, wake_rise;
  logic                wake_any, settle_done, settle_load, settle_run;
  pm_state_e           state;
  deep_phase_e         phase;
  logic [NUM_WAKE-1:0] cause_q;

  pmc_wake_sync #(.N(NUM_WAKE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wake_in),
    .level(wake_level), .rise(wake_rise)
  );

  assign wake_any = |wake_rise;

  pmc_settle_cnt #(.W(SETTLE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .run(settle_run),
    .load_val(settle_cycles), .done(settle_done)
  );

  pmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_req_valid(sw_req_valid),
    .sw_req_code(sw_req_code), .cpu_irq(cpu_irq), .dma_bus_req(dma_bus_req),
    .bus_grant(bus_grant), .wake_any(wake_any), .settle_done(settle_done),
    .state(state), .phase(phase), .settle_load(settle_load),
    .settle_run(settle_run)
  );

  pmc_outdec #(.NUM_PLL(NUM_PLL)) u_dec (
    .state(state), .phase(phase), .ring_level(wake_level[WAKE_RING]),
    .cpu_half_rate(cpu_half_rate), .bus_req(bus_req),
    .sdram_self_refresh(sdram_self_refresh), .clk_gate_en(clk_gate_en),
    .osc_en(osc_en), .pll_en(pll_en), .ring_irq(ring_irq)
  );

  // sticky wake record; a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cause_q <= '0;
    else
      cause_q <= (cause_clr ? '0 : cause_q)
               | (wake_armed(state, phase) ? wake_rise : '0);
  end

  assign pm_state   = state;
  assign wake_cause = cause_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int NUM_PLL = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         pm_state,
  input logic               bus_grant,
  input logic               cpu_irq,
  input logic               dma_bus_req,
  input logic               bus_req,
  input logic               sdram_self_refresh,
  input logic               clk_gate_en,
  input logic               osc_en,
  input logic [NUM_PLL-1:0] pll_en,
  input logic               ring_irq,
  input logic               cpu_half_rate,
  input logic               wake_any
);
  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd3 && $past(pm_state) != 3'd3) |->
      ($past(pm_state) == 3'd2 && $past(bus_grant)));

  // R11
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd4 && $past(pm_state) != 3'd4) |-> $past(pm_state) == 3'd3);

  // R4
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd2 && (cpu_irq || dma_bus_req)) |=> pm_state == 3'd0);

  // R6
  sleep_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd3) |-> (bus_req && sdram_self_refresh && !clk_gate_en && osc_en));

  // R7
  deep_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en) |-> (pll_en == '0 && sdram_self_refresh && pm_state == 3'd4));

  // R12
  clock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en) |-> (osc_en && $past(osc_en)));

  // R9
  ring_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_irq |-> (pm_state <= 3'd2));

  // R3
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_half_rate |-> (!sdram_self_refresh && !bus_req && pm_state == 3'd1));

  // R8
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd3 && wake_any) |=> pm_state == 3'd0);
endmodule

bind pmc_top pmc_chk #(.NUM_PLL(NUM_PLL)) chk_i (.*);

// File: tb/pmc_top_tb_top.sv
module pmc_top_tb_top;
  localparam int NUM_PLL = 2;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_req_valid = 1'b0;
  logic [2:0]    sw_req_code = 3'd0;
  logic          cpu_irq = 1'b0, dma_bus_req = 1'b0, bus_grant = 1'b0;
  logic [3:0]    wake_in = 4'd0;
  logic [SW-1:0] settle_cycles = 16'd3;
  logic          cause_clr = 1'b0;
  logic [2:0]    pm_state;
  logic          cpu_half_rate, bus_req, sdram_self_refresh, clk_gate_en, osc_en;
  logic [NUM_PLL-1:0] pll_en;
  logic          ring_irq;
  logic [3:0]    wake_cause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pmc_top #(.NUM_PLL(NUM_PLL), .SETTLE_W(SW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input logic [2:0] code);
    sw_req_valid = 1'b1; sw_req_code = code;
    step(1);
    sw_req_valid = 1'b0;
  endtask

  // wake source pulse; state has moved after the third rising edge
  task automatic wake_pulse(input int bitn);
    wake_in[bitn] = 1'b1;
    step(3);
  endtask

  task automatic wake_drop();
    wake_in = 4'd0;
    step(4);
  endtask

  task automatic go_sleep();
    request(3'd2);
    bus_grant = 1'b1;
    request(3'd3);
    bus_grant = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", 32'(pm_state), 0);
    chk("R2 run outputs", {cpu_half_rate, bus_req, sdram_self_refresh, clk_gate_en, osc_en, pll_en},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11});
    chk("R10 cause at reset", 32'(wake_cause), 0);
    chk("R9 ring at reset", 32'(ring_irq), 0);
  endtask

  task automatic t_slow();
    request(3'd1);
    chk("R3 slow state", 32'(pm_state), 1);
    chk("R3 half rate", {cpu_half_rate, sdram_self_refresh, clk_gate_en, osc_en}, 4'b1011);
    sw_req_valid = 1'b0; sw_req_code = 3'd0; step(1);
    chk("R1 no valid no change", 32'(pm_state), 1);
    request(3'd0);
    chk("R3 back to run", {pm_state, cpu_half_rate}, {3'd0, 1'b0});
  endtask

  task automatic t_gating();
    bus_grant = 1'b1;
    request(3'd3);
    chk("R5 sleep from run ignored", {pm_state, sdram_self_refresh}, {3'd0, 1'b0});
    request(3'd4);
    chk("R11 deep from run ignored", {pm_state, osc_en}, {3'd0, 1'b1});
    bus_grant = 1'b0;
    request(3'd2);
    chk("R4 idle bus request", {pm_state, bus_req}, {3'd2, 1'b1});
    request(3'd3);
    chk("R5 sleep without grant ignored", 32'(pm_state), 2);
    request(3'd4);
    chk("R11 deep from idle ignored", 32'(pm_state), 2);
    cpu_irq = 1'b1; bus_grant = 1'b1;
    request(3'd3);
    cpu_irq = 1'b0; bus_grant = 1'b0;
    chk("R4 irq beats sleep request", {pm_state, bus_req}, {3'd0, 1'b0});
    request(3'd2);
    dma_bus_req = 1'b1; step(1); dma_bus_req = 1'b0;
    chk("R4 dma exits idle", 32'(pm_state), 0);
  endtask

  task automatic t_sleep_wake();
    go_sleep();
    chk("R6 sleep outputs", {pm_state, sdram_self_refresh, clk_gate_en, bus_req, osc_en},
        {3'd3, 1'b1, 1'b0, 1'b1, 1'b1});
    request(3'd0);
    chk("R8 run request ignored in sleep", 32'(pm_state), 3);
    wake_in[3] = 1'b1;
    step(2);
    chk("R9 ring masked in sleep", {pm_state, ring_irq}, {3'd3, 1'b0});
    step(1);
    chk("R8 ring wake to run", {pm_state, sdram_self_refresh, clk_gate_en}, {3'd0, 1'b0, 1'b1});
    chk("R9 ring passed when awake", 32'(ring_irq), 1);
    chk("R10 ring cause", 32'(wake_cause), 32'h8);
    wake_drop();
    chk("R9 ring irq follows level", 32'(ring_irq), 0);
    cause_clr = 1'b1; step(1); cause_clr = 1'b0;
    chk("R10 cause cleared", 32'(wake_cause), 0);
    go_sleep();
    wake_pulse(0);
    chk("R8 on-key wake", {pm_state, wake_cause}, {3'd0, 4'h1});
    wake_drop();
    go_sleep();
    wake_in[2] = 1'b1;
    step(2);
    cause_clr = 1'b1; step(1); cause_clr = 1'b0;
    chk("R10 edge wins over clear", {pm_state, wake_cause}, {3'd0, 4'h4});
    wake_drop();
    cause_clr = 1'b1; step(1); cause_clr = 1'b0;
  endtask

  task automatic t_deep();
    go_sleep();
    request(3'd4);
    chk("R7 deep outputs", {pm_state, osc_en, pll_en, sdram_self_refresh, clk_gate_en},
        {3'd4, 1'b0, 2'b00, 1'b1, 1'b0});
    request(3'd0);
    chk("R11 request ignored in deep", {pm_state, osc_en}, {3'd4, 1'b0});
    wake_in[1] = 1'b1;
    step(2);
    chk("R12 still off before edge", 32'(osc_en), 0);
    step(1);
    chk("R12 osc and plls up", {osc_en, pll_en, clk_gate_en, sdram_self_refresh}, {1'b1, 2'b11, 1'b0, 1'b1});
    chk("R10 alarm cause", 32'(wake_cause), 32'h2);
    step(2);
    chk("R12 still settling", {pm_state, clk_gate_en}, {3'd4, 1'b0});
    step(1);
    chk("R12 release after count", {pm_state, clk_gate_en, sdram_self_refresh}, {3'd4, 1'b1, 1'b0});
    step(1);
    chk("R12 run after release", {pm_state, bus_req}, {3'd0, 1'b0});
    wake_drop();
    settle_cycles = 16'd0;
    go_sleep();
    request(3'd4);
    wake_pulse(0);
    chk("R12 zero count settle", {osc_en, clk_gate_en}, {1'b1, 1'b0});
    step(1);
    chk("R12 zero count acts as one", {pm_state, clk_gate_en}, {3'd4, 1'b1});
    step(1);
    chk("R12 zero count run", 32'(pm_state), 0);
    wake_drop();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_slow();
    t_gating();
    t_sleep_wake();
    t_deep();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule